// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block picks one interrupt request per cycle. It weighs the requests against two CPU mask bits: a global mask and a user mask. A non-maskable request and an address-break request are always accepted. The eight maskable IRQ lines each take a control level of 0 or 1. Each control bit sets the level of one pair of adjacent lines. The level decides two things: which mask setting lets the line through, and where the line ranks.

An accepted non-maskable request always wins. Accepted level-1 lines come next, then address break, then accepted level-0 lines. Inside a level, the lower line index wins. The result is registered. The valid flag and the encoded source ID appear one clock after the inputs that produced them.

Requests are level-sensitive and are not latched. A masked line simply stays asserted. It wins on the first cycle after its mask condition clears. Vector fetch, stacking and exception sequencing belong to the CPU, not to this block.

Top module: `intr_level_arbiter`

## Requirements
- R1: A non-maskable request is always accepted and always wins, giving ID 0 whatever the mask bits, levels or other requests.
- R2: An address-break request is accepted under any mask setting and gives ID 1. It loses only to a non-maskable request and to an accepted level-1 line. It beats every level-0 line.
- R3: A level-0 line is accepted only while the global mask is 0.
- R4: A level-1 line is accepted while either mask bit is 0. With both mask bits at 1, only the non-maskable and address-break requests can be granted.
- R5: An IRQ line whose enable bit is 0 is never a candidate and has no effect on the output.
- R6: Bit k of the level input sets the level of IRQ lines 2k and 2k+1. A value of 1 means level 1 and 0 means level 0.
- R7: IRQ line n is reported as ID 2+n. Within one level, the lower line index wins.
- R8: The outputs are registered and reflect the inputs sampled at the previous rising clock edge. A line held while masked wins on the first registered cycle after its mask condition clears.
- R9: When no request is accepted, and during reset, the valid output is 0 and the ID output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| nmiReq | input | 1 | Non-maskable request |
| brkReq | input | 1 | Address-break request |
| irqReq | input | 8 | Maskable IRQ request lines, level-sensitive |
| irqEn | input | 8 | Per-line enable bits |
| pairLevel | input | 4 | Control level per pair of IRQ lines |
| maskI | input | 1 | Global interrupt mask |
| maskUi | input | 1 | User interrupt mask |
| grantValid | output | 1 | A request was accepted on the previous edge |
| grantId | output | 4 | Winning source: 0 non-maskable, 1 address break, 2+n for IRQ n |

## Verification
The assertions check several rules on every cycle:
- a non-maskable request always leads to ID 0 on the next cycle;
- address break wins when level-1 lines are shut out;
- full masking leaves the output idle;
- disabled lines never produce a grant;
- an idle output carries ID 0 and the ID stays in its legal range.

The ordering between level-1 lines, address break and level-0 lines needs a reference model, and so does the effect of each pair-level bit. The bench compares every cycle of a sweep against a behavioural rank model. The sweep covers all mask pairs, all level settings and every request pattern. Directed scenarios show a pending line winning as soon as its mask clears.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

  localparam int ID_NMI      = 0;
  localparam int ID_BRK      = 1;
  localparam int ID_IRQ_BASE = 2;

  // Strobes from the mask control to the pick datapath.
  typedef struct packed {
    logic openLvl0;   // level-0 lines may be accepted
    logic openLvl1;   // level-1 lines may be accepted
  } gateStrobes_t;

endpackage

// File: rtl/arb_gate_ctrl.sv
module arb_gate_ctrl
  import intr_arb_pkg::*;
(
  input  logic         maskI,
  input  logic         maskUi,
  output gateStrobes_t gates
);

  // The global mask alone closes level 0.
  // Level 1 closes only when both masks are set.
  always_comb begin
    gates.openLvl0 = !maskI;
    gates.openLvl1 = !(maskI && maskUi);
  end

endmodule

// File: rtl/arb_pick_dp.sv
module arb_pick_dp
  import intr_arb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int ID_W    = $clog2(NUM_IRQ + ID_IRQ_BASE)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiReq,
  input  logic                 brkReq,
  input  logic [NUM_IRQ-1:0]   irqReq,
  input  logic [NUM_IRQ-1:0]   irqEn,
  input  logic [NUM_IRQ/2-1:0] pairLevel,
  input  gateStrobes_t         gates,
  output logic                 grantValid,
  output logic [ID_W-1:0]      grantId
);

  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int MAX_ID = ID_IRQ_BASE + NUM_IRQ - 1;

  logic [NUM_IRQ-1:0] levelOfIrq;
  logic [NUM_IRQ-1:0] liveReq;
  logic [NUM_IRQ-1:0] candLvl1;
  logic [NUM_IRQ-1:0] candLvl0;
  logic [IDX_W-1:0]   pickLvl1;
  logic [IDX_W-1:0]   pickLvl0;
  logic               nextValid;
  logic [ID_W-1:0]    nextId;

  // One level bit covers two adjacent lines.
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_pairMap
    assign levelOfIrq[n] = pairLevel[n/2];
  end

  assign liveReq  = irqReq & irqEn;
  assign candLvl1 = liveReq &  levelOfIrq & {NUM_IRQ{gates.openLvl1}};
  assign candLvl0 = liveReq & ~levelOfIrq & {NUM_IRQ{gates.openLvl0}};

  // Lowest set index wins within a level.
  always_comb begin
    pickLvl1 = '0;
    pickLvl0 = '0;
    for (int n = NUM_IRQ - 1; n >= 0; n--) begin
      if (candLvl1[n]) pickLvl1 = IDX_W'(n);
      if (candLvl0[n]) pickLvl0 = IDX_W'(n);
    end
  end

  // Rank: NMI, level-1 lines, address break, level-0 lines.
  always_comb begin
    nextValid = 1'b1;
    nextId    = '0;
    if (nmiReq) begin
      nextId = ID_W'(ID_NMI);
    end else if (|candLvl1) begin
      nextId = ID_W'(ID_IRQ_BASE) + ID_W'(pickLvl1);
    end else if (brkReq) begin
      nextId = ID_W'(ID_BRK);
    end else if (|candLvl0) begin
      nextId = ID_W'(ID_IRQ_BASE) + ID_W'(pickLvl0);
    end else begin
      nextValid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantId    <= '0;
    end else begin
      grantValid <= nextValid;
      grantId    <= nextId;
    end
  end

  AST_NMI_TOP: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> (grantValid && grantId == ID_W'(ID_NMI))); // R1
  AST_BRK_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && !nmiReq && !gates.openLvl1) |=> (grantValid && grantId == ID_W'(ID_BRK))); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!gates.openLvl1 && !nmiReq && !brkReq) |=> !grantValid); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiReq && !brkReq && ((irqReq & irqEn) == '0)) |=> !grantValid); // R5
  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantId <= ID_W'(MAX_ID))); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grantId == '0)); // R9

endmodule

// File: rtl/intr_level_arbiter.sv
module intr_level_arbiter
  import intr_arb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int ID_W    = $clog2(NUM_IRQ + ID_IRQ_BASE)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiReq,
  input  logic                 brkReq,
  input  logic [NUM_IRQ-1:0]   irqReq,
  input  logic [NUM_IRQ-1:0]   irqEn,
  input  logic [NUM_IRQ/2-1:0] pairLevel,
  input  logic                 maskI,
  input  logic                 maskUi,
  output logic                 grantValid,
  output logic [ID_W-1:0]      grantId
);

  gateStrobes_t gates;

  arb_gate_ctrl u_ctrl (
    .maskI  (maskI),
    .maskUi (maskUi),
    .gates  (gates)
  );

  arb_pick_dp #(
    .NUM_IRQ (NUM_IRQ),
    .ID_W    (ID_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .nmiReq     (nmiReq),
    .brkReq     (brkReq),
    .irqReq     (irqReq),
    .irqEn      (irqEn),
    .pairLevel  (pairLevel),
    .gates      (gates),
    .grantValid (grantValid),
    .grantId    (grantId)
  );

endmodule

// File: tb/intr_level_arbiter_tb.sv
module intr_level_arbiter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nmiReq = 1'b0;
  logic       brkReq = 1'b0;
  logic [7:0] irqReq = '0;
  logic [7:0] irqEn = '0;
  logic [3:0] pairLevel = '0;
  logic       maskI = 1'b0;
  logic       maskUi = 1'b0;
  logic       grantValid;
  logic [3:0] grantId;

  int total = 0;
  int bad = 0;
  logic doneFlag = 1'b0;

  always #10 clk = ~clk;

  intr_level_arbiter u_dut (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .brkReq(brkReq),
    .irqReq(irqReq), .irqEn(irqEn), .pairLevel(pairLevel),
    .maskI(maskI), .maskUi(maskUi),
    .grantValid(grantValid), .grantId(grantId)
  );

  // Rank-based reference: smaller rank wins.
  function automatic void refModel(output logic v, output logic [3:0] id, output string tag);
    int best = 1000;
    int bestId = 0;
    if (nmiReq) begin best = 0; bestId = 0; end
    if (brkReq && 20 < best) begin best = 20; bestId = 1; end
    for (int n = 0; n < 8; n++) begin
      if (irqReq[n] && irqEn[n]) begin
        int rank = 1000;
        if (pairLevel[n/2] && (!maskI || !maskUi)) rank = 10 + n;
        else if (!pairLevel[n/2] && !maskI) rank = 30 + n;
        if (rank < best) begin best = rank; bestId = 2 + n; end
      end
    end
    v  = (best < 1000);
    id = v ? 4'(bestId) : 4'd0;
    if (best == 0) tag = "R1";
    else if (best == 20) tag = "R2";
    else if (best < 20) tag = "R4";
    else if (best < 1000) tag = "R3";
    else tag = "R9";
  endfunction

  task automatic compare(input string tag, input logic ev, input logic [3:0] eid);
    total++;
    if (grantValid !== ev || grantId !== eid) begin
      bad++;
      $display("FAIL %s: valid=%0b id=%0d expected valid=%0b id=%0d",
               tag, grantValid, grantId, ev, eid);
    end
  endtask

  // Apply current inputs through one edge, check against the model.
  task automatic stepModel(input string extraTag);
    logic ev; logic [3:0] eid; string tag;
    @(posedge clk);
    refModel(ev, eid, tag);
    @(negedge clk);
    compare(extraTag.len() > 0 ? extraTag : tag, ev, eid);
  endtask

  // Directed step with an explicit expectation.
  task automatic stepExpect(input string tag, input logic ev, input logic [3:0] eid);
    @(posedge clk);
    @(negedge clk);
    compare(tag, ev, eid);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R9", 1'b0, 4'd0);  // R9 reset state
    rstN = 1'b1;

    // R6: bit 1 sets IRQ2 and IRQ3 to level 1, so IRQ3 beats address break.
    irqEn = 8'hFF; pairLevel = 4'b0010; irqReq = 8'b0000_1001; brkReq = 1'b1;
    stepExpect("R6", 1'b1, 4'd5);
    // R2: the level-0 IRQ0 loses to address break.
    irqReq = 8'b0000_0001;
    stepExpect("R2", 1'b1, 4'd1);
    // R7: lower index wins within level 0.
    brkReq = 1'b0; pairLevel = 4'b0000; irqReq = 8'b1010_0000;
    stepExpect("R7", 1'b1, 4'd7);
    // R5: a disabled line has no effect.
    irqEn = 8'hDF;
    stepExpect("R5", 1'b1, 4'd9);
    irqEn = 8'h00;
    stepExpect("R5", 1'b0, 4'd0);
    // R3: a level-0 line is held while maskI=1.
    irqEn = 8'hFF; irqReq = 8'b0000_0100; maskI = 1'b1; maskUi = 1'b0;
    stepExpect("R3", 1'b0, 4'd0);
    // R8: the pending line wins on the first cycle after the mask clears.
    maskI = 1'b0;
    stepExpect("R8", 1'b1, 4'd4);
    // R4: full mask holds a level-1 line; only NMI gets through.
    pairLevel = 4'b1111; maskI = 1'b1; maskUi = 1'b1;
    stepExpect("R4", 1'b0, 4'd0);
    nmiReq = 1'b1;
    stepExpect("R1", 1'b1, 4'd0);
    nmiReq = 1'b0; maskUi = 1'b0;
    stepExpect("R8", 1'b1, 4'd4);

    // Sweep: masks, levels, enables and all request patterns.
    for (int mi = 0; mi < 2; mi++)
      for (int mu = 0; mu < 2; mu++)
        for (int lv = 0; lv < 16; lv++)
          for (int es = 0; es < 2; es++)
            for (int pat = 0; pat < 1024; pat++) begin
              maskI = 1'(mi); maskUi = 1'(mu); pairLevel = 4'(lv);
              irqEn = es ? 8'h5A : 8'hFF;
              irqReq = pat[7:0]; brkReq = pat[8]; nmiReq = pat[9];
              stepModel("");
            end

    doneFlag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule